// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This unit is the on-chip data store of a small 8-bit microcontroller core. It holds 128 bytes of RAM. The lowest 32 bytes hold four switchable banks of eight working registers. A 16-byte window above them can be reached one bit at a time. An 8-bit stack pointer grows upward through the RAM. The core's decoder issues at most one request per cycle on a synchronous request port. Each request carries an operation code, an 8-bit address or register number, write data and the 2-bit bank select.

The unit decides where each request goes from its addressing mode as well as its address. Direct byte accesses and bit accesses at 80H and above go out on a special-register bus, which the peripherals serve. Indirect accesses and stack accesses at 80H and above never reach that bus. They are flagged as invalid. Reads return data one cycle after the request. A small two-state machine tracks whether the response slot holds a read. ST_IDLE moves to ST_RESP on the transition T_READ_ISSUE, when a read request is taken. ST_RESP stays in ST_RESP on T_READ_AGAIN, when another read arrives. ST_RESP returns to ST_IDLE on T_READ_DONE, when the cycle carries no read.

Top module: `idm_unit`

## Requirements
- R1: After reset the stack pointer is 07H, every RAM byte reads 00H, and rsp_valid and bad_access are low.
- R2: Operation codes on req_op are 0 none, 1 register read, 2 register write, 3 direct read, 4 direct write, 5 indirect read, 6 indirect write, 7 bit set, 8 bit clear, 9 bit read, 10 push, 11 pop and 12 stack-pointer load. A register access to Rn (n = req_addr[2:0]) uses RAM byte bank_sel*8 + n, so bank 2 places R0 at 10H and R7 at 17H.
- R3: A direct access below 80H uses RAM byte req_addr. At 80H or above it raises sfr_re (read) or sfr_we (write) in the same cycle, with sfr_addr = req_addr, sfr_bit = 0 and sfr_wdata = req_wdata, and it leaves the RAM unchanged. A direct read returns the sfr_rdata value seen in the request cycle.
- R4: An indirect access below 80H uses RAM byte req_addr. At 80H or above it raises no SFR strobe, a write is dropped, a read returns 00H, and bad_access is high in the following cycle.
- R5: A bit address b below 80H selects bit b[2:0] of RAM byte 20H + b[6:3]. Set and clear change only that bit, in one cycle. A bit read returns the bit in rsp_data[0] with rsp_data[7:1] = 0.
- R6: A bit address b at 80H or above goes to the SFR bus with sfr_bit = 1, sfr_addr = {b[7:3],000} and sfr_bit_idx = b[2:0]. Set and clear raise sfr_we with sfr_wdata = 01H for set and 00H for clear. A bit read raises sfr_re and returns sfr_rdata[b[2:0]] in rsp_data[0].
- R7: A push increments SP modulo 256 and then writes req_wdata at the new SP. If the new SP is 80H or above, the write is dropped and bad_access rises in the following cycle.
- R8: A pop returns the byte at SP and then decrements SP modulo 256. If SP is 80H or above, the pop returns 00H with bad_access in the following cycle, and SP still decrements.
- R9: A stack-pointer load sets SP to req_wdata, so a load of 4FH puts the next push at 50H.
- R10: Every read operation (1, 3, 5, 9, 11) gives rsp_valid high in exactly the following cycle, including back-to-back reads. A cycle without a read gives rsp_valid low in the next cycle, and then rsp_data is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see R2) |
| req_addr | input | 8 | Byte address, bit address or register number |
| req_wdata | input | 8 | Write, push or SP-load data |
| bank_sel | input | 2 | Active register bank |
| rsp_valid | output | 1 | Read data valid (cycle after the read) |
| rsp_data | output | 8 | Read data |
| bad_access | output | 1 | Previous request touched the upper half indirectly |
| sp_out | output | 8 | Current stack pointer |
| sfr_re | output | 1 | Special-register read strobe |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_bit | output | 1 | Strobe is a single-bit access |
| sfr_addr | output | 8 | Special-register byte address |
| sfr_bit_idx | output | 3 | Bit index for bit accesses |
| sfr_wdata | output | 8 | Write data, or 00H/01H for a bit clear/set |
| sfr_rdata | input | 8 | Special-register read data, same cycle |

## Verification
Each addressing mode is tried on both sides of the 80H boundary. Direct and indirect accesses to the same upper address must separate into an SFR strobe in one case and an invalid flag in the other. Register traffic is run in all four banks with distinct values, so a wrong bank base or a collision between banks shows up as a wrong byte in direct read-back. Bit operations are aimed at the first, last and an inner bit of the window and at two special-register addresses, which shows whether the byte and bit are chosen correctly. Stack traffic covers the reset position, a relocated stack, the FFH-to-00H wrap and a push past 7FH, and back-to-back reads are followed by an idle cycle to check when the response slot opens and closes.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_REG_RD  = 4'd1,
        OP_REG_WR  = 4'd2,
        OP_DIR_RD  = 4'd3,
        OP_DIR_WR  = 4'd4,
        OP_IND_RD  = 4'd5,
        OP_IND_WR  = 4'd6,
        OP_BIT_SET = 4'd7,
        OP_BIT_CLR = 4'd8,
        OP_BIT_RD  = 4'd9,
        OP_PUSH    = 4'd10,
        OP_POP     = 4'd11,
        OP_SP_LD   = 4'd12
    } idm_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_SFR  = 2'd2,
        TGT_BAD  = 2'd3
    } idm_tgt_e;

    typedef struct packed {
        idm_tgt_e   tgt;
        logic       is_read;
        logic       is_write;
        logic       is_bit;
        logic       bit_val;
        logic [6:0] ram_idx;
        logic [2:0] bit_idx;
        logic [7:0] sfr_addr;
    } idm_route_t;

    function automatic logic op_reads(idm_op_e op);
        return (op == OP_REG_RD) || (op == OP_DIR_RD) || (op == OP_IND_RD) ||
               (op == OP_BIT_RD) || (op == OP_POP);
    endfunction

endpackage

// File: rtl/idm_route.sv
module idm_route
    import idm_pkg::*;
#(
    parameter int REGS_PER_BANK = 8,
    parameter int BANK_W        = 2,
    parameter int BIT_BASE      = 32
) (
    input  idm_op_e     op,
    input  logic [7:0]  addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]  sp,
    output idm_route_t  route
);
    localparam logic [6:0] REGS_C  = 7'(REGS_PER_BANK);
    localparam logic [6:0] BBASE_C = 7'(BIT_BASE);

    logic [7:0] push_addr;

    always_comb begin
        push_addr = sp + 8'd1;
        route = '0;
        route.tgt = TGT_NONE;
        unique case (op)
            OP_REG_RD, OP_REG_WR: begin
                route.tgt      = TGT_RAM;
                route.ram_idx  = 7'(bank) * REGS_C + 7'(addr[2:0]);
                route.is_read  = (op == OP_REG_RD);
                route.is_write = (op == OP_REG_WR);
            end
            OP_DIR_RD, OP_DIR_WR: begin
                route.tgt      = addr[7] ? TGT_SFR : TGT_RAM;
                route.ram_idx  = addr[6:0];
                route.sfr_addr = addr;
                route.is_read  = (op == OP_DIR_RD);
                route.is_write = (op == OP_DIR_WR);
            end
            OP_IND_RD, OP_IND_WR: begin
                route.tgt      = addr[7] ? TGT_BAD : TGT_RAM;
                route.ram_idx  = addr[6:0];
                route.is_read  = (op == OP_IND_RD);
                route.is_write = (op == OP_IND_WR);
            end
            OP_BIT_SET, OP_BIT_CLR, OP_BIT_RD: begin
                route.tgt      = addr[7] ? TGT_SFR : TGT_RAM;
                route.is_bit   = 1'b1;
                route.bit_val  = (op == OP_BIT_SET);
                route.ram_idx  = BBASE_C + 7'(addr[6:3]);
                route.bit_idx  = addr[2:0];
                route.sfr_addr = {addr[7:3], 3'b000};
                route.is_read  = (op == OP_BIT_RD);
                route.is_write = (op != OP_BIT_RD);
            end
            OP_PUSH: begin
                route.tgt      = push_addr[7] ? TGT_BAD : TGT_RAM;
                route.ram_idx  = push_addr[6:0];
                route.is_write = 1'b1;
            end
            OP_POP: begin
                route.tgt      = sp[7] ? TGT_BAD : TGT_RAM;
                route.ram_idx  = sp[6:0];
                route.is_read  = 1'b1;
            end
            default: route.tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/idm_sp.sv
module idm_sp #(
    parameter int         W        = 8,
    parameter logic [7:0] RESET_SP = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sp
);
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= W'(RESET_SP);
        else if (load) sp <= load_val;
        else if (inc)  sp <= sp + W'(1);
        else if (dec)  sp <= sp - W'(1);
    end
endmodule

// File: rtl/idm_unit.sv
module idm_unit
    import idm_pkg::*;
#(
    parameter int         RAM_BYTES     = 128,
    parameter int         REGS_PER_BANK = 8,
    parameter int         BANK_W        = 2,
    parameter int         BIT_BASE      = 32,
    parameter logic [7:0] RESET_SP      = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [3:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [7:0]  req_wdata,
    input  logic [1:0]  bank_sel,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        bad_access,
    output logic [7:0]  sp_out,
    output logic        sfr_re,
    output logic        sfr_we,
    output logic        sfr_bit,
    output logic [7:0]  sfr_addr,
    output logic [2:0]  sfr_bit_idx,
    output logic [7:0]  sfr_wdata,
    input  logic [7:0]  sfr_rdata
);
    localparam int RAM_AW = $clog2(RAM_BYTES);

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RESP = 1'b1} rsp_state_e;

    idm_op_e    op;
    idm_route_t route;
    logic [7:0] sp;
    logic [7:0] ram_rdata, ram_wdata, mod_byte, read_next, rsp_data_q;
    logic       ram_we, take_read, bad_q;
    logic       on_ram, on_sfr, on_bad;
    rsp_state_e state_q, state_d;

    assign op = idm_op_e'(req_op);

    idm_route #(
        .REGS_PER_BANK(REGS_PER_BANK), .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
    ) u_route (
        .op(op), .addr(req_addr), .bank(bank_sel[BANK_W-1:0]), .sp(sp), .route(route)
    );

    assign on_ram = req_valid && (route.tgt == TGT_RAM);
    assign on_sfr = req_valid && (route.tgt == TGT_SFR);
    assign on_bad = req_valid && (route.tgt == TGT_BAD);

    // one-cycle read-modify-write for bit operations
    always_comb begin
        mod_byte = ram_rdata;
        mod_byte[route.bit_idx] = route.bit_val;
    end

    assign ram_we    = on_ram && route.is_write;
    assign ram_wdata = route.is_bit ? mod_byte : req_wdata;

    idm_ram #(.DEPTH(RAM_BYTES), .W(8)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we),
        .waddr(route.ram_idx[RAM_AW-1:0]), .wdata(ram_wdata),
        .raddr(route.ram_idx[RAM_AW-1:0]), .rdata(ram_rdata)
    );

    idm_sp #(.W(8), .RESET_SP(RESET_SP)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .inc(req_valid && op == OP_PUSH),
        .dec(req_valid && op == OP_POP),
        .load(req_valid && op == OP_SP_LD),
        .load_val(req_wdata), .sp(sp)
    );
    assign sp_out = sp;

    // special-register bus, combinational in the request cycle
    always_comb begin
        sfr_re      = on_sfr && route.is_read;
        sfr_we      = on_sfr && route.is_write;
        sfr_bit     = on_sfr && route.is_bit;
        sfr_addr    = on_sfr ? route.sfr_addr : 8'h00;
        sfr_bit_idx = on_sfr ? route.bit_idx : 3'd0;
        sfr_wdata   = 8'h00;
        if (on_sfr && route.is_write)
            sfr_wdata = route.is_bit ? {7'b0, route.bit_val} : req_wdata;
    end

    always_comb begin
        read_next = 8'h00;
        unique case (route.tgt)
            TGT_RAM: read_next = route.is_bit ? {7'b0, ram_rdata[route.bit_idx]} : ram_rdata;
            TGT_SFR: read_next = route.is_bit ? {7'b0, sfr_rdata[route.bit_idx]} : sfr_rdata;
            default: read_next = 8'h00;
        endcase
    end

    assign take_read = req_valid && op_reads(op);

    // response state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_read) state_d = ST_RESP;   // T_READ_ISSUE
            ST_RESP: state_d = take_read ? ST_RESP        // T_READ_AGAIN
                                         : ST_IDLE;       // T_READ_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_q <= 8'h00;
            bad_q      <= 1'b0;
        end else begin
            rsp_data_q <= take_read ? read_next : 8'h00;
            bad_q      <= on_bad;
        end
    end

    // outputs
    always_comb begin
        rsp_valid  = (state_q == ST_RESP);
        rsp_data   = (state_q == ST_RESP) ? rsp_data_q : 8'h00;
        bad_access = bad_q;
    end

    // R4: indirect access never strobes the special-register bus
    a_r4_ind_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == OP_IND_RD || op == OP_IND_WR)) |-> (!sfr_re && !sfr_we));

    // R3: direct upper-half read goes out as a read strobe only
    a_r3_dir_upper_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_DIR_RD && req_addr[7]) |-> (sfr_re && !sfr_we && sfr_addr == req_addr));

    // R7: push advances SP by one
    a_r7_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_PUSH) |=> (sp_out == $past(sp_out) + 8'd1));

    // R8: pop retreats SP by one
    a_r8_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_POP) |=> (sp_out == $past(sp_out) - 8'd1));

    // R10: a read gets its response slot in the next cycle
    a_r10_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_reads(op)) |=> rsp_valid);

    // R4: an invalid read returns zero
    a_r4_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_access && rsp_valid) |-> (rsp_data == 8'h00));

    // R6: special-register strobes are never both high
    a_r6_sfr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sfr_re, sfr_we}));
endmodule

// File: tb/idm_unit_tb.sv
`timescale 1ns/100ps
module idm_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_op = 4'd0;
    logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic rsp_valid, bad_access, sfr_re, sfr_we, sfr_bit;
    logic [7:0] rsp_data, sp_out, sfr_addr, sfr_wdata, sfr_rdata;
    logic [2:0] sfr_bit_idx;

    int total = 0, bad = 0;
    int ram [128];
    int sp_m;
    logic [7:0] sfr_mem [256];

    always #2.5 clk = ~clk;

    idm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .bank_sel(bank_sel),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bad_access(bad_access),
        .sp_out(sp_out), .sfr_re(sfr_re), .sfr_we(sfr_we), .sfr_bit(sfr_bit),
        .sfr_addr(sfr_addr), .sfr_bit_idx(sfr_bit_idx), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    // special-register slave
    assign sfr_rdata = sfr_mem[sfr_addr];
    always @(posedge clk) begin
        if (sfr_we) begin
            if (sfr_bit) sfr_mem[sfr_addr][sfr_bit_idx] <= sfr_wdata[0];
            else         sfr_mem[sfr_addr] <= sfr_wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int op, input int addr, input int wd, input int bank, input string tag);
        int e_re = 0, e_we = 0, e_bit = 0, e_sa = 0, e_idx = 0, e_swd = 0;
        int e_rd = 0, e_data = 0, e_bad = 0, a, bi;
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'(op); req_addr = 8'(addr);
        req_wdata = 8'(wd); bank_sel = 2'(bank);
        case (op)
            1: begin a = bank * 8 + (addr & 7); e_rd = 1; e_data = ram[a]; end
            2: begin a = bank * 8 + (addr & 7); ram[a] = wd; end
            3: begin e_rd = 1;
                if (addr >= 128) begin e_re = 1; e_sa = addr; e_data = sfr_mem[addr]; end
                else e_data = ram[addr]; end
            4: if (addr >= 128) begin e_we = 1; e_sa = addr; e_swd = wd; end
               else ram[addr] = wd;
            5: begin e_rd = 1; if (addr >= 128) e_bad = 1; else e_data = ram[addr]; end
            6: if (addr >= 128) e_bad = 1; else ram[addr] = wd;
            7, 8, 9: begin
                bi = addr & 7;
                if (addr >= 128) begin
                    e_bit = 1; e_sa = addr & 8'hF8; e_idx = bi;
                    if (op == 9) begin e_re = 1; e_rd = 1; e_data = (sfr_mem[e_sa] >> bi) & 1; end
                    else begin e_we = 1; e_swd = (op == 7) ? 1 : 0; end
                end else begin
                    a = 32 + (addr >> 3);
                    if (op == 7) ram[a] = ram[a] | (1 << bi);
                    else if (op == 8) ram[a] = ram[a] & ~(1 << bi);
                    else begin e_rd = 1; e_data = (ram[a] >> bi) & 1; end
                end
            end
            10: begin sp_m = (sp_m + 1) & 255; if (sp_m >= 128) e_bad = 1; else ram[sp_m] = wd; end
            11: begin e_rd = 1; if (sp_m >= 128) e_bad = 1; else e_data = ram[sp_m];
                sp_m = (sp_m - 1) & 255; end
            12: sp_m = wd;
            default: ;
        endcase
        #1;
        chk({tag, " sfr_re"}, int'(sfr_re), e_re);
        chk({tag, " sfr_we"}, int'(sfr_we), e_we);
        if (e_re || e_we) begin
            chk({tag, " sfr_addr"}, int'(sfr_addr), e_sa);
            chk({tag, " sfr_bit"}, int'(sfr_bit), e_bit);
            if (e_bit) chk({tag, " sfr_bit_idx"}, int'(sfr_bit_idx), e_idx);
            if (e_we) chk({tag, " sfr_wdata"}, int'(sfr_wdata), e_swd);
        end
        @(posedge clk); #1;
        chk({tag, " rsp_valid"}, int'(rsp_valid), e_rd);
        if (e_rd) chk({tag, " rsp_data"}, int'(rsp_data), e_data);
        chk({tag, " bad_access"}, int'(bad_access), e_bad);
        chk({tag, " sp"}, int'(sp_out), sp_m);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_op = 4'd0;
        @(posedge clk); #1;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 0);
        chk({tag, " rsp_data"}, int'(rsp_data), 0);
        chk({tag, " bad_access"}, int'(bad_access), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) ram[i] = 0;
        for (int i = 0; i < 256; i++) sfr_mem[i] = 8'(i ^ 8'h5A);
        sp_m = 7;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset sp", int'(sp_out), 8'h07);
        chk("R1 reset rsp_valid", int'(rsp_valid), 0);
        chk("R1 reset bad_access", int'(bad_access), 0);
        step(3, 8'h00, 0, 0, "R1 ram 00");
        step(3, 8'h1F, 0, 0, "R1 ram 1F");
        step(5, 8'h7F, 0, 0, "R1 ram 7F");
        // R2: all banks
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++)
                step(2, n, 8'h40 + b * 8 + n, b, "R2 reg wr");
        step(3, 8'h10, 0, 0, "R2 bank2 R0 at 10H");
        step(3, 8'h17, 0, 0, "R2 bank2 R7 at 17H");
        step(1, 5, 0, 3, "R2 bank3 R5");
        step(1, 0, 0, 1, "R2 bank1 R0");
        // R3: direct
        step(4, 8'h30, 8'hAA, 0, "R3 dir wr ram");
        step(3, 8'h30, 0, 0, "R3 dir rd ram");
        step(4, 8'h90, 8'h3C, 0, "R3 dir wr sfr");
        step(3, 8'h90, 0, 0, "R3 dir rd sfr");
        step(3, 8'h10, 0, 0, "R3 ram untouched by sfr wr");
        // R4: indirect
        step(6, 8'h90, 8'h77, 0, "R4 ind wr upper");
        step(5, 8'h90, 0, 0, "R4 ind rd upper");
        step(3, 8'h90, 0, 0, "R4 sfr untouched");
        step(5, 8'h30, 0, 0, "R4 ind rd ram");
        step(6, 8'h31, 8'h5C, 0, "R4 ind wr ram");
        step(3, 8'h31, 0, 0, "R4 ind wr readback");
        // R5: bit window
        step(7, 8'h00, 0, 0, "R5 set bit 00");
        step(7, 8'h7F, 0, 0, "R5 set bit 7F");
        step(7, 8'h0B, 0, 0, "R5 set bit 0B");
        step(7, 8'h0D, 0, 0, "R5 set bit 0D");
        step(8, 8'h0B, 0, 0, "R5 clr bit 0B");
        step(3, 8'h20, 0, 0, "R5 byte 20");
        step(3, 8'h2F, 0, 0, "R5 byte 2F");
        step(3, 8'h21, 0, 0, "R5 byte 21");
        step(9, 8'h0D, 0, 0, "R5 rd bit 0D");
        step(9, 8'h0B, 0, 0, "R5 rd bit 0B");
        // R6: special-register bits
        step(7, 8'h93, 0, 0, "R6 set sfr bit");
        step(9, 8'h93, 0, 0, "R6 rd sfr bit set");
        step(8, 8'h93, 0, 0, "R6 clr sfr bit");
        step(9, 8'h93, 0, 0, "R6 rd sfr bit clr");
        step(9, 8'hE5, 0, 0, "R6 rd sfr E5");
        step(3, 8'h90, 0, 0, "R6 sfr byte after bits");
        // R7/R8/R9: stack
        step(10, 0, 8'h11, 0, "R7 first push at 08");
        step(3, 8'h08, 0, 0, "R7 push landed 08");
        step(11, 0, 0, 0, "R8 pop");
        step(12, 0, 8'h4F, 0, "R9 sp load 4F");
        step(10, 0, 8'h22, 0, "R9 push at 50");
        step(3, 8'h50, 0, 0, "R9 byte 50");
        step(12, 0, 8'hFF, 0, "R9 sp load FF");
        step(10, 0, 8'h33, 0, "R7 push wrap to 00");
        step(11, 0, 0, 0, "R8 pop wrap to FF");
        step(12, 0, 8'h7F, 0, "R9 sp load 7F");
        step(10, 0, 8'h44, 0, "R7 push past 7F");
        step(11, 0, 0, 0, "R8 pop at 80");
        step(3, 8'h7F, 0, 0, "R7 7F untouched");
        // R10: back-to-back reads then idle
        step(1, 2, 0, 2, "R10 rd a");
        step(3, 8'h12, 0, 0, "R10 rd b");
        idle("R10 idle after reads");
        step(2, 1, 8'h99, 0, "R10 write no rsp");
        idle("R10 idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule